// File: doc/BRIEF.md
# Lock-Guarded Board Control Register Bank

This block is a small bank of board status and control registers on a plain 32-bit register bus. A bus master presents a select, a write flag, a byte address and write data; the bank answers with read data and an error flag one clock later. The bank holds a board identity word, an LED word that also drives the LED pins, two free configuration words, a volatile flag word and a non-volatile flag word that have separate set and clear addresses, a lock word, a reset-level word and a display-control word.

The reset-level word is protected by the lock. It accepts writes only while the lock holds the key value. An accepted write that has the board's reset bit set sends a one-cycle reset request. A 12-bit board code in the identity word selects one of several board behaviours. The code decides where the reset bit sits, whether the reset-level word exists, which display-control bits software may change, and whether the low display bits drive a 2-bit display mux-select output. The identity word is a strap input. It is sampled while reset is held and must stay steady afterwards.

Top module: `sysctl_regs`

## Requirements
- R1: A clocked reset (rstN low at a rising edge) sets the LED word, lock, both configuration words, volatile flags and reset level to zero. Display control becomes 0x1F00, or 0 when the board code is 0x190. Offset 0x00 returns idWord, 0x04 returns 0, 0x44 returns 1 and 0x88 returns 0xFF000000. Writes to these four offsets are ignored.
- R2: The non-volatile flag word (read at 0x38) keeps its value through reset. Its power-up content is undefined.
- R3: A write to the lock word (0x20, read back at 0x20) with data exactly 0x0000A05F stores 0xA05F and opens the lock. Any other write stores data[15:0] with bit 15 cleared, which leaves the lock closed.
- R4: A write to 0x30 ORs the data into the volatile flags. A write to 0x34 clears every flag bit that is 1 in the data. The flags read at 0x30, and 0x34 reads 0.
- R5: Writes to 0x38 and 0x3C set and clear the non-volatile flags in the same way.
- R6: For board codes 0x100, 0x178 and 0x182, a write to 0x40 is stored and read back only while the lock holds 0xA05F. Otherwise the write is dropped.
- R7: An accepted 0x40 write raises resetReq for exactly the one cycle after the write edge, if the write data has the board's reset bit set. The reset bit is bit 8 for board 0x100 and bit 2 for boards 0x178 and 0x182.
- R8: For every other board code, offset 0x40 reads 0, ignores writes and never raises resetReq.
- R9: For boards 0x100 and 0x140, a display-control write (0x50) keeps bits 13:8 and takes every other bit from the data.
- R10: For boards 0x178 and 0x182, a display-control write keeps bit 7 and takes every other bit from the data.
- R11: For board 0x190 and unknown board codes, display control ignores writes. On 0x190 it reads 0.
- R12: muxSel equals display-control bits 1:0 on board 0x100 and is 0 on every other board.
- R13: An access to an offset outside the map, including any address that is not word aligned, reads 0, changes no state and raises busErr for the one cycle after the access.
- R14: The LED word (0x08) and the configuration words (0x28, 0x2C) read back what was last written, and ledOut follows the LED word. Read data and busErr are valid in the cycle after the access edge. busRdata is 0 when there is no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| idWord | input | 32 | Board identity strap; bits 27:16 hold the board code |
| busSel | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| busErr | output | 1 | One-cycle unmapped-access flag |
| ledOut | output | 32 | LED word |
| resetReq | output | 1 | One-cycle reset request |
| muxSel | output | 2 | Display mux select |

## Verification
The bench closes the lock in several ways: with an arbitrary value, with 0xFFFF and with a word whose low 16 bits equal the key but whose upper bits do not. A design that compared only 16 bits, or that forgot to clear bit 15, would open the lock and accept a reset-level write it should drop. On each board variant, the bench drives reset-level data with only the other variant's reset bit set. A design that used a single bit position would send a reset request there. The bench writes all ones and then a crafted pattern to display control on each board, so a wrong mask or a mask on the wrong board shows up in the readback, and a mux driven off board 0x100 shows up on muxSel. It also checks that the non-volatile flags survive a reset, and it sends unaligned and out-of-map accesses, which must flag an error yet leave the LED word unchanged.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 12;
  localparam int BOARD_LSB = 16;
  localparam int BOARD_W   = 12;
  localparam int LOCK_W    = 16;
  localparam int BIT_IDX_W = $clog2(DATA_W);

  // board codes carried in the identity word
  localparam logic [BOARD_W-1:0] BRD_CODE_MUXED  = 12'h100;
  localparam logic [BOARD_W-1:0] BRD_CODE_PLAIN  = 12'h140;
  localparam logic [BOARD_W-1:0] BRD_CODE_LATE_A = 12'h178;
  localparam logic [BOARD_W-1:0] BRD_CODE_LATE_B = 12'h182;
  localparam logic [BOARD_W-1:0] BRD_CODE_MIN    = 12'h190;

  localparam logic [LOCK_W-1:0] LOCK_KEY = 16'hA05F;

  // register map (byte offsets)
  localparam logic [ADDR_W-1:0] OFF_ID       = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_SW       = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_LED      = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_LOCK     = 12'h020;
  localparam logic [ADDR_W-1:0] OFF_CFG_A    = 12'h028;
  localparam logic [ADDR_W-1:0] OFF_CFG_B    = 12'h02C;
  localparam logic [ADDR_W-1:0] OFF_FLAG_SET = 12'h030;
  localparam logic [ADDR_W-1:0] OFF_FLAG_CLR = 12'h034;
  localparam logic [ADDR_W-1:0] OFF_NV_SET   = 12'h038;
  localparam logic [ADDR_W-1:0] OFF_NV_CLR   = 12'h03C;
  localparam logic [ADDR_W-1:0] OFF_RST_LVL  = 12'h040;
  localparam logic [ADDR_W-1:0] OFF_BUS_CTL  = 12'h044;
  localparam logic [ADDR_W-1:0] OFF_DISP     = 12'h050;
  localparam logic [ADDR_W-1:0] OFF_CPU_ID   = 12'h088;

  localparam logic [DATA_W-1:0] DISP_INIT       = 32'h0000_1F00;
  localparam logic [DATA_W-1:0] DISP_FIELD_MASK = 32'h0000_3F00;
  localparam logic [DATA_W-1:0] DISP_BIT_MASK   = 32'h0000_0080;
  localparam logic [DATA_W-1:0] CONST_BUS_CTL   = 32'h0000_0001;
  localparam logic [DATA_W-1:0] CONST_CPU_ID    = 32'hFF00_0000;

  localparam logic [BIT_IDX_W-1:0] RST_BIT_MUXED = 5'd8;
  localparam logic [BIT_IDX_W-1:0] RST_BIT_LATE  = 5'd2;

  typedef enum logic [2:0] {
    BOARD_MUXED,
    BOARD_PLAIN,
    BOARD_LATE,
    BOARD_MIN,
    BOARD_UNKNOWN
  } boardKindT;

  typedef enum logic [3:0] {
    RD_ZERO,
    RD_ID,
    RD_LED,
    RD_LOCK,
    RD_CFG_A,
    RD_CFG_B,
    RD_FLAGS,
    RD_NVFLAGS,
    RD_RSTLVL,
    RD_BUS_CTL,
    RD_DISP,
    RD_CPU_ID
  } rdSrcT;

  typedef enum logic [1:0] {
    DISP_FIELD_RO,
    DISP_BIT_KEEP,
    DISP_FROZEN
  } dispModeT;

  typedef struct packed {
    logic                 wrLed;
    logic                 wrLock;
    logic                 wrCfgA;
    logic                 wrCfgB;
    logic                 wrFlagSet;
    logic                 wrFlagClr;
    logic                 wrNvSet;
    logic                 wrNvClr;
    logic                 wrRstLvl;
    logic                 wrDisp;
    logic                 rdEn;
    rdSrcT                rdSrc;
    dispModeT             dispMode;
    logic [BIT_IDX_W-1:0] rstBitIdx;
  } strobeT;

endpackage

// File: rtl/sysctl_setclr.sv
module sysctl_setclr #(
  parameter int W    = 32,
  parameter bit KEEP = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         setEn,
  input  logic         clrEn,
  input  logic [W-1:0] data,
  output logic [W-1:0] q
);

  generate
    if (KEEP) begin : g_keep
      // content survives the clocked reset
      logic unusedRst;
      assign unusedRst = rstN;
      always_ff @(posedge clk) begin
        if (setEn)      q <= q | data;
        else if (clrEn) q <= q & ~data;
      end
    end else begin : g_clear
      always_ff @(posedge clk) begin
        if (!rstN)      q <= '0;
        else if (setEn) q <= q | data;
        else if (clrEn) q <= q & ~data;
      end
    end
  endgenerate

endmodule

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BOARD_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [BW-1:0] boardCode,
  input  logic          busSel,
  input  logic          busWrite,
  input  logic [AW-1:0] busAddr,
  input  logic          lockOpen,
  output strobeT        stb,
  output boardKindT     board,
  output logic          busErr
);

  logic wrAcc;
  logic rdAcc;
  logic mapped;
  logic rstCapable;
  dispModeT dispMode;

  always_comb begin
    case (boardCode)
      BRD_CODE_MUXED:                  board = BOARD_MUXED;
      BRD_CODE_PLAIN:                  board = BOARD_PLAIN;
      BRD_CODE_LATE_A, BRD_CODE_LATE_B: board = BOARD_LATE;
      BRD_CODE_MIN:                    board = BOARD_MIN;
      default:                         board = BOARD_UNKNOWN;
    endcase
  end

  always_comb begin
    rstCapable = (board == BOARD_MUXED) || (board == BOARD_LATE);
    case (board)
      BOARD_MUXED, BOARD_PLAIN: dispMode = DISP_FIELD_RO;
      BOARD_LATE:               dispMode = DISP_BIT_KEEP;
      default:                  dispMode = DISP_FROZEN;
    endcase
  end

  assign wrAcc = busSel & busWrite;
  assign rdAcc = busSel & ~busWrite;

  always_comb begin
    stb           = '0;
    stb.rdSrc     = RD_ZERO;
    stb.dispMode  = dispMode;
    stb.rstBitIdx = (board == BOARD_MUXED) ? RST_BIT_MUXED : RST_BIT_LATE;
    stb.rdEn      = rdAcc;
    mapped        = 1'b1;
    case (busAddr)
      OFF_ID:       stb.rdSrc = RD_ID;
      OFF_SW:       stb.rdSrc = RD_ZERO;
      OFF_LED: begin
        stb.rdSrc = RD_LED;
        stb.wrLed = wrAcc;
      end
      OFF_LOCK: begin
        stb.rdSrc  = RD_LOCK;
        stb.wrLock = wrAcc;
      end
      OFF_CFG_A: begin
        stb.rdSrc  = RD_CFG_A;
        stb.wrCfgA = wrAcc;
      end
      OFF_CFG_B: begin
        stb.rdSrc  = RD_CFG_B;
        stb.wrCfgB = wrAcc;
      end
      OFF_FLAG_SET: begin
        stb.rdSrc     = RD_FLAGS;
        stb.wrFlagSet = wrAcc;
      end
      OFF_FLAG_CLR: stb.wrFlagClr = wrAcc;
      OFF_NV_SET: begin
        stb.rdSrc   = RD_NVFLAGS;
        stb.wrNvSet = wrAcc;
      end
      OFF_NV_CLR:   stb.wrNvClr = wrAcc;
      OFF_RST_LVL: begin
        stb.rdSrc    = (board == BOARD_MIN) ? RD_ZERO : RD_RSTLVL;
        stb.wrRstLvl = wrAcc & lockOpen & rstCapable;
      end
      OFF_BUS_CTL:  stb.rdSrc = RD_BUS_CTL;
      OFF_DISP: begin
        stb.rdSrc  = RD_DISP;
        stb.wrDisp = wrAcc & (dispMode != DISP_FROZEN);
      end
      OFF_CPU_ID:   stb.rdSrc = RD_CPU_ID;
      default:      mapped = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) busErr <= 1'b0;
    else       busErr <= busSel & ~mapped;
  end

endmodule

// File: rtl/sysctl_dpath.sv
module sysctl_dpath
  import sysctl_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int LW = LOCK_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] idWord,
  input  logic [DW-1:0] busWdata,
  input  strobeT        stb,
  input  boardKindT     board,
  output logic          lockOpen,
  output logic [DW-1:0] busRdata,
  output logic [DW-1:0] ledOut,
  output logic          resetReq,
  output logic [1:0]    muxSel
);

  logic [DW-1:0] ledQ;
  logic [LW-1:0] lockQ;
  logic [DW-1:0] cfgAQ;
  logic [DW-1:0] cfgBQ;
  logic [DW-1:0] rstLvlQ;
  logic [DW-1:0] dispQ;
  logic [DW-1:0] flagsQ;
  logic [DW-1:0] nvFlagsQ;
  logic [DW-1:0] dispNext;
  logic [DW-1:0] dispInit;
  logic [DW-1:0] rdVal;

  sysctl_setclr #(.W(DW), .KEEP(1'b0)) u_flags (
    .clk   (clk),
    .rstN  (rstN),
    .setEn (stb.wrFlagSet),
    .clrEn (stb.wrFlagClr),
    .data  (busWdata),
    .q     (flagsQ)
  );

  sysctl_setclr #(.W(DW), .KEEP(1'b1)) u_nvFlags (
    .clk   (clk),
    .rstN  (rstN),
    .setEn (stb.wrNvSet),
    .clrEn (stb.wrNvClr),
    .data  (busWdata),
    .q     (nvFlagsQ)
  );

  assign lockOpen = (lockQ == LOCK_KEY);
  assign dispInit = (board == BOARD_MIN) ? '0 : DISP_INIT;

  always_comb begin
    case (stb.dispMode)
      DISP_FIELD_RO: dispNext = (dispQ & DISP_FIELD_MASK) | (busWdata & ~DISP_FIELD_MASK);
      DISP_BIT_KEEP: dispNext = (dispQ & DISP_BIT_MASK) | (busWdata & ~DISP_BIT_MASK);
      default:       dispNext = dispQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ledQ     <= '0;
      lockQ    <= '0;
      cfgAQ    <= '0;
      cfgBQ    <= '0;
      rstLvlQ  <= '0;
      dispQ    <= dispInit;
      resetReq <= 1'b0;
    end else begin
      if (stb.wrLed)  ledQ  <= busWdata;
      if (stb.wrCfgA) cfgAQ <= busWdata;
      if (stb.wrCfgB) cfgBQ <= busWdata;
      if (stb.wrLock) begin
        if (busWdata == DW'(LOCK_KEY)) lockQ <= LOCK_KEY;
        else                           lockQ <= {1'b0, busWdata[LW-2:0]};
      end
      if (stb.wrRstLvl) rstLvlQ <= busWdata;
      if (stb.wrDisp)   dispQ   <= dispNext;
      resetReq <= stb.wrRstLvl & busWdata[stb.rstBitIdx];
    end
  end

  always_comb begin
    case (stb.rdSrc)
      RD_ID:      rdVal = idWord;
      RD_LED:     rdVal = ledQ;
      RD_LOCK:    rdVal = DW'(lockQ);
      RD_CFG_A:   rdVal = cfgAQ;
      RD_CFG_B:   rdVal = cfgBQ;
      RD_FLAGS:   rdVal = flagsQ;
      RD_NVFLAGS: rdVal = nvFlagsQ;
      RD_RSTLVL:  rdVal = rstLvlQ;
      RD_BUS_CTL: rdVal = CONST_BUS_CTL;
      RD_DISP:    rdVal = dispQ;
      RD_CPU_ID:  rdVal = CONST_CPU_ID;
      default:    rdVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         busRdata <= '0;
    else if (stb.rdEn) busRdata <= rdVal;
    else               busRdata <= '0;
  end

  assign ledOut = ledQ;
  assign muxSel = (board == BOARD_MUXED) ? dispQ[1:0] : 2'b00;

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] idWord,
  input  logic          busSel,
  input  logic          busWrite,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] busRdata,
  output logic          busErr,
  output logic [DW-1:0] ledOut,
  output logic          resetReq,
  output logic [1:0]    muxSel
);

  strobeT    stb;
  boardKindT board;
  logic      lockOpen;

  sysctl_ctrl #(.AW(AW), .BW(BOARD_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .boardCode (idWord[BOARD_LSB +: BOARD_W]),
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .lockOpen  (lockOpen),
    .stb       (stb),
    .board     (board),
    .busErr    (busErr)
  );

  sysctl_dpath #(.DW(DW), .LW(LOCK_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .idWord   (idWord),
    .busWdata (busWdata),
    .stb      (stb),
    .board    (board),
    .lockOpen (lockOpen),
    .busRdata (busRdata),
    .ledOut   (ledOut),
    .resetReq (resetReq),
    .muxSel   (muxSel)
  );

endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk
  import sysctl_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [DATA_W-1:0]   idWord,
  input logic                busSel,
  input logic                busWrite,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [DATA_W-1:0]   busWdata,
  input logic                busErr,
  input logic                resetReq,
  input logic [1:0]          muxSel,
  input logic                lockOpen
);

  logic [BOARD_W-1:0] code;
  assign code = idWord[BOARD_LSB +: BOARD_W];

  // R6: a request needs an unlocked write to the reset-level word one cycle earlier
  assert_req_needs_unlock_R6: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(busSel && busWrite && (busAddr == OFF_RST_LVL) && lockOpen));

  // R8: boards without a reset-level word never request a reset
  assert_req_board_R8: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (code == BRD_CODE_MUXED || code == BRD_CODE_LATE_A || code == BRD_CODE_LATE_B));

  // R3: any write to the lock other than the key leaves it closed
  assert_lock_close_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == OFF_LOCK && busWdata != DATA_W'(LOCK_KEY)) |=> !lockOpen);

  // R3: the key opens the lock
  assert_lock_open_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == OFF_LOCK && busWdata == DATA_W'(LOCK_KEY)) |=> lockOpen);

  // R13: the error flag only follows an access
  assert_err_follows_access_R13: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(busSel));

  // R12: the mux select stays zero off the muxed board
  assert_mux_board_R12: assert property (@(posedge clk) disable iff (!rstN)
    (muxSel != 2'b00) |-> (code == BRD_CODE_MUXED));

endmodule

bind sysctl_regs sysctl_regs_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .idWord   (idWord),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busErr   (busErr),
  .resetReq (resetReq),
  .muxSel   (muxSel),
  .lockOpen (lockOpen)
);

// File: tb/sysctl_regs_test.sv
module sysctl_regs_test;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit          chkData;
    logic [31:0] expData;
    bit          expErr;
    bit          expReq;
    string       tag;
  } sbItemT;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] idWord = 32'h0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busErr;
  logic [31:0] ledOut;
  logic        resetReq;
  logic [1:0]  muxSel;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  sbItemT sbQ[$];

  sysctl_regs uut (
    .clk      (clk),
    .rstN     (rstN),
    .idWord   (idWord),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .busErr   (busErr),
    .ledOut   (ledOut),
    .resetReq (resetReq),
    .muxSel   (muxSel)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: compares queued expectations once results are registered
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sbQ.size() > 0) begin
        sbItemT it;
        it = sbQ.pop_front();
        if (it.chkData) check(busRdata === it.expData, {it.tag, " rdata"}, busRdata, it.expData);
        check(busErr === it.expErr, {it.tag, " err"}, 32'(busErr), 32'(it.expErr));
        check(resetReq === it.expReq, {it.tag, " resetReq"}, 32'(resetReq), 32'(it.expReq));
      end
    end
  end

  task automatic access(input bit w, input logic [11:0] a, input logic [31:0] d,
                        input bit cd, input logic [31:0] ed, input bit ee, input bit er,
                        input string tag);
    sbItemT it;
    @(negedge clk);
    busSel = 1'b1; busWrite = w; busAddr = a; busWdata = d;
    it.chkData = cd; it.expData = ed; it.expErr = ee; it.expReq = er; it.tag = tag;
    sbQ.push_back(it);
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    access(1'b0, a, 32'h0, 1'b1, exp, 1'b0, 1'b0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    access(1'b1, a, d, 1'b0, 32'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic wrReq(input logic [11:0] a, input logic [31:0] d, input bit er, input string tag);
    access(1'b1, a, d, 1'b0, 32'h0, 1'b0, er, tag);
  endtask

  task automatic boardReset(input logic [31:0] id);
    @(negedge clk);
    rstN = 1'b0; idWord = id;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // ---------- board 0x100 ----------
    boardReset(32'h4100_0123);
    rd(12'h000, 32'h4100_0123, "R1 id");
    rd(12'h004, 32'h0, "R1 sw");
    rd(12'h008, 32'h0, "R1 led");
    rd(12'h020, 32'h0, "R1 lock");
    rd(12'h028, 32'h0, "R1 cfgA");
    rd(12'h02C, 32'h0, "R1 cfgB");
    rd(12'h030, 32'h0, "R1 flags");
    rd(12'h040, 32'h0, "R1 rstlvl");
    rd(12'h044, 32'h1, "R1 busctl");
    rd(12'h050, 32'h1F00, "R1 disp");
    rd(12'h088, 32'hFF00_0000, "R1 cpuid");
    wr(12'h000, 32'hDEAD_BEEF, "R1 id write");
    wr(12'h044, 32'h0, "R1 busctl write");
    rd(12'h000, 32'h4100_0123, "R1 id after write");
    rd(12'h044, 32'h1, "R1 busctl after write");

    // R14 plain read/write
    wr(12'h008, 32'h0000_005A, "R14 led");
    rd(12'h008, 32'h0000_005A, "R14 led");
    check(ledOut === 32'h5A, "R14 ledOut", ledOut, 32'h5A);
    wr(12'h028, 32'h1234_5678, "R14 cfgA");
    wr(12'h02C, 32'h8765_4321, "R14 cfgB");
    rd(12'h028, 32'h1234_5678, "R14 cfgA");
    rd(12'h02C, 32'h8765_4321, "R14 cfgB");

    // R4 volatile flags
    wr(12'h030, 32'h0000_F0F0, "R4 set");
    wr(12'h030, 32'h0000_000F, "R4 set");
    rd(12'h030, 32'h0000_F0FF, "R4 after set");
    wr(12'h034, 32'h0000_00F3, "R4 clr");
    rd(12'h030, 32'h0000_F00C, "R4 after clr");
    rd(12'h034, 32'h0, "R4 clr alias reads 0");

    // R5 non-volatile flags
    wr(12'h03C, 32'hFFFF_FFFF, "R5 clr all");
    wr(12'h038, 32'h0000_8001, "R5 set");
    wr(12'h03C, 32'h0000_0001, "R5 clr");
    rd(12'h038, 32'h0000_8000, "R5 value");

    // R3 / R6 lock handling
    wrReq(12'h040, 32'h0000_0104, 1'b0, "R6 locked write");
    rd(12'h040, 32'h0, "R6 locked write dropped");
    wr(12'h020, 32'h0000_1234, "R3 lock other");
    rd(12'h020, 32'h0000_1234, "R3 lock other");
    wr(12'h020, 32'h0000_FFFF, "R3 lock bit15");
    rd(12'h020, 32'h0000_7FFF, "R3 lock bit15 cleared");
    wr(12'h020, 32'h0001_A05F, "R3 lock near key");
    rd(12'h020, 32'h0000_205F, "R3 lock near key");
    wrReq(12'h040, 32'h0000_0104, 1'b0, "R6 near key still locked");
    rd(12'h040, 32'h0, "R6 still locked");
    wr(12'h020, 32'h0000_A05F, "R3 key");
    rd(12'h020, 32'h0000_A05F, "R3 key stored");

    // R7 reset bit on board 0x100
    wrReq(12'h040, 32'h0000_0104, 1'b1, "R7 bit8 pulse");
    rd(12'h040, 32'h0000_0104, "R6 stored");
    wrReq(12'h040, 32'h0000_0004, 1'b0, "R7 bit2 ignored on 0x100");
    rd(12'h040, 32'h0000_0004, "R6 stored again");

    // R9 / R12 display on board 0x100
    wr(12'h050, 32'h0000_2A03, "R9 disp");
    rd(12'h050, 32'h0000_1F03, "R9 field kept");
    check(muxSel === 2'd3, "R12 mux", 32'(muxSel), 32'd3);
    wr(12'h050, 32'hFFFF_FFFF, "R9 disp ones");
    rd(12'h050, 32'hFFFF_DFFF, "R9 ones");
    wr(12'h050, 32'h0000_0001, "R12 disp");
    check(muxSel === 2'd1, "R12 mux follow", 32'(muxSel), 32'd1);

    // R13 unmapped and unaligned
    access(1'b0, 12'h0FC, 32'h0, 1'b1, 32'h0, 1'b1, 1'b0, "R13 unmapped read");
    access(1'b1, 12'h0FC, 32'hFFFF_FFFF, 1'b0, 32'h0, 1'b1, 1'b0, "R13 unmapped write");
    access(1'b1, 12'h009, 32'h0000_00FF, 1'b0, 32'h0, 1'b1, 1'b0, "R13 unaligned write");
    rd(12'h008, 32'h0000_005A, "R13 led unchanged, err cleared");

    // ---------- board 0x178 ----------
    boardReset(32'h0178_0000);
    rd(12'h038, 32'h0000_8000, "R2 nv kept through reset");
    rd(12'h030, 32'h0, "R1 flags cleared");
    rd(12'h020, 32'h0, "R1 lock cleared");
    rd(12'h008, 32'h0, "R1 led cleared");
    check(ledOut === 32'h0, "R1 ledOut cleared", ledOut, 32'h0);
    rd(12'h028, 32'h0, "R1 cfgA cleared");
    rd(12'h050, 32'h1F00, "R1 disp 0x178");
    wr(12'h050, 32'h0000_0003, "R12 disp");
    check(muxSel === 2'd0, "R12 mux off 0x178", 32'(muxSel), 32'd0);
    wr(12'h050, 32'hFFFF_FFFF, "R10 disp ones");
    rd(12'h050, 32'hFFFF_FF7F, "R10 bit7 kept");
    wr(12'h020, 32'h0000_A05F, "R3 key");
    wrReq(12'h040, 32'h0000_0100, 1'b0, "R7 bit8 ignored on 0x178");
    wrReq(12'h040, 32'h0000_0004, 1'b1, "R7 bit2 pulse");
    rd(12'h040, 32'h0000_0004, "R6 stored 0x178");

    // ---------- board 0x182 ----------
    boardReset(32'h0182_0000);
    wr(12'h050, 32'h0000_0000, "R10 disp zero");
    rd(12'h050, 32'h0000_0000, "R10 0x182");
    wr(12'h020, 32'h0000_A05F, "R3 key");
    wrReq(12'h040, 32'h0000_0004, 1'b1, "R7 0x182 pulse");

    // ---------- board 0x140 ----------
    boardReset(32'h0140_0000);
    wr(12'h020, 32'h0000_A05F, "R3 key");
    wrReq(12'h040, 32'h0000_0104, 1'b0, "R8 0x140 no pulse");
    rd(12'h040, 32'h0, "R8 0x140 reads 0");
    wr(12'h050, 32'h0000_2A03, "R9 0x140 disp");
    rd(12'h050, 32'h0000_1F03, "R9 0x140");
    check(muxSel === 2'd0, "R12 mux off 0x140", 32'(muxSel), 32'd0);

    // ---------- board 0x190 ----------
    boardReset(32'h0190_0000);
    rd(12'h050, 32'h0, "R11 0x190 disp zero");
    wr(12'h050, 32'hFFFF_FFFF, "R11 0x190 disp write");
    rd(12'h050, 32'h0, "R11 0x190 ignored");
    wr(12'h020, 32'h0000_A05F, "R3 key");
    wrReq(12'h040, 32'h0000_0104, 1'b0, "R8 0x190 no pulse");
    rd(12'h040, 32'h0, "R8 0x190 reads 0");

    // ---------- unknown board ----------
    boardReset(32'h00AB_0000);
    rd(12'h050, 32'h1F00, "R11 unknown disp reset");
    wr(12'h050, 32'h0000_0000, "R11 unknown disp write");
    rd(12'h050, 32'h1F00, "R11 unknown ignored");
    wr(12'h020, 32'h0000_A05F, "R3 key");
    wrReq(12'h040, 32'h0000_0104, 1'b0, "R8 unknown no pulse");
    rd(12'h040, 32'h0, "R8 unknown reads 0");

    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule